// File: doc/BRIEF.md
# Serial Wiper Controller with Busy Handshake

This block is the digital side of a multi-channel digitally controlled resistor. A host sends 24-bit frames over a four-wire serial port: chip select, serial clock, data in and an open-drain data out. The block keeps one volatile 10-bit wiper code and one stored (nonvolatile) copy for each channel. Writes to a wiper take effect at once. Operations on the stored copies are slow, and while one runs the `rdy` output stays low.

Each frame carries a command in bits 23:20, an address in bits 19:16 and data in bits 15:0, with the code in bits 9:0. The command runs when chip select rises, and only if exactly 24 bits were clocked in. While a frame is being clocked in, the data line shifts out the last accepted frame. A falling edge on the asynchronous active-low `preset_n` input reloads every wiper from its stored copy. The busy times are cycle counts set by parameters, so the real millisecond delays and short simulation delays come from the same RTL.

Inside the block, all serial and preset inputs pass through synchronizers clocked by `clk`. A three-state controller (IDLE, WAIT, APPLY) moves between its states as follows:
- IDLE goes to WAIT when a slow command is accepted or a preset edge arrives.
- WAIT goes to APPLY when the busy timer reaches its last count.
- APPLY goes to IDLE after one cycle, and the deferred operation takes effect in that cycle.

Top module: `dpot_serial_ctrl`

## Requirements
- R1: During and after reset `rdy` is 1, every wiper code and stored copy is 0x200, `sdo_pull` is 0, and the readback frame is all zeros.
- R2: Command 1 writes bits 9:0 of the data field into the wiper addressed by the address field as soon as chip select rises, and `rdy` stays high.
- R3: A frame with any bit count other than 24 has no effect, does not drop `rdy` and does not replace the readback frame.
- R4: Data in is sampled on rising serial-clock edges, most significant bit first. Frames behave the same whether the clock idles low or high.
- R5: While chip select is low, the data line shifts out the last accepted frame, MSB first, one bit per rising clock edge; a 0 bit pulls the line low. While chip select is high, `sdo_pull` is 0.
- R6: Command 2 copies the addressed wiper into its stored copy. `rdy` is low for LONG_CYCLES+1 clock cycles.
- R7: Command 3 loads the addressed wiper from its stored copy after a busy time of LONG_CYCLES+1 cycles.
- R8: Command 8 loads every wiper from its stored copy after a busy time of MID_CYCLES+1 cycles.
- R9: Command 9 writes data bits 9:0 into the addressed stored copy, and command 10 sets that copy to 0x200. Each takes a busy time of SHORT_CYCLES+1 cycles.
- R10: A frame whose chip select falls while `rdy` is low, or that ends while `rdy` is low, has no effect. The readback frame keeps its old value.
- R11: A falling edge of `preset_n` in IDLE holds `rdy` low for PRESET_CYCLES+1 cycles and then loads every wiper from its stored copy. A preset edge that arrives while busy is dropped.
- R12: Commands other than 1, 2, 3, 8, 9 and 10 change nothing and leave `rdy` high. An address of CHANNELS or above touches no channel.
- R13: Wiper codes do not change while `rdy` is low. A deferred result becomes visible in the same cycle that `rdy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; may idle low or high |
| sdi | input | 1 | Serial data in |
| sdo_pull | output | 1 | 1 pulls the open-drain data line low |
| preset_n | input | 1 | Asynchronous active-low reload request |
| rdy | output | 1 | 1 when idle; 0 while a slow operation runs |
| wiper_codes | output | CHANNELS*CODE_W | Wiper codes; channel i in bits [i*CODE_W +: CODE_W] |

## Verification
Directed frames cover each command in both clock idle levels, with codes at 0x3FF, 0x200, alternating patterns and 0x001. This shows whether bit order and the data field position are correct. Frames of 23 and 25 bits separate bit counting from the command decode. A frame started during a busy period shows that rejection and readback retention are handled apart from plain execution. The measured length of each low period on `rdy` separates the long, medium and short busy classes. Seeded random frames mix the commands, addresses (valid and out of range) and frame lengths. They are checked against a model of the wipers and stored copies, so a wrong channel select or a stored copy taken at the wrong time shows up.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;

    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_APPLY = 2'd2
    } ctrl_state_t;

    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_SET_WIPER   = 3'd1,
        OP_SAVE        = 3'd2,
        OP_RESTORE     = 3'd3,
        OP_RESTORE_ALL = 3'd4,
        OP_NV_LOAD     = 3'd5,
        OP_NV_MID      = 3'd6
    } op_t;

    typedef enum logic [1:0] {
        DLY_NONE  = 2'd0,
        DLY_LONG  = 2'd1,
        DLY_MID   = 2'd2,
        DLY_SHORT = 2'd3
    } dly_t;

    function automatic op_t decode_op(input logic [CMD_W-1:0] c);
        case (c)
            4'd1:    return OP_SET_WIPER;
            4'd2:    return OP_SAVE;
            4'd3:    return OP_RESTORE;
            4'd8:    return OP_RESTORE_ALL;
            4'd9:    return OP_NV_LOAD;
            4'd10:   return OP_NV_MID;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic dly_t decode_dly(input logic [CMD_W-1:0] c);
        case (c)
            4'd2, 4'd3:  return DLY_LONG;
            4'd8:        return DLY_MID;
            4'd9, 4'd10: return DLY_SHORT;
            default:     return DLY_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
`timescale 1ns/1ps
module spi_frame_rx #(
    parameter int FRAME_BITS  = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic [FRAME_BITS-1:0] readback,
    output logic                  sdo_pull,
    output logic                  cs_fall,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [SYNC_STAGES-1:0] cs_sh, sck_sh, sdi_sh;
    logic                   cs_d, sck_d;
    logic                   cs_q, sck_q, sdi_q;
    logic                   cs_rise, sck_rise;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_BITS-1:0]  in_sr, out_sr;

    assign cs_q  = cs_sh[SYNC_STAGES-1];
    assign sck_q = sck_sh[SYNC_STAGES-1];
    assign sdi_q = sdi_sh[SYNC_STAGES-1];

    // input synchronizers plus one edge-detect stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh  <= '1;
            sck_sh <= '0;
            sdi_sh <= '0;
            cs_d   <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_sh  <= {cs_sh[SYNC_STAGES-2:0], cs_n};
            sck_sh <= {sck_sh[SYNC_STAGES-2:0], sclk};
            sdi_sh <= {sdi_sh[SYNC_STAGES-2:0], sdi};
            cs_d   <= cs_q;
            sck_d  <= sck_q;
        end
    end

    assign cs_fall  = cs_d & ~cs_q;
    assign cs_rise  = ~cs_d & cs_q;
    assign sck_rise = ~sck_d & sck_q & ~cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sr   <= '0;
            out_sr  <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
            out_sr  <= readback;
        end else if (sck_rise) begin
            in_sr   <= {in_sr[FRAME_BITS-2:0], sdi_q};
            out_sr  <= {out_sr[FRAME_BITS-2:0], 1'b0};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_valid = cs_rise && (bit_cnt == CNT_FULL);
    assign frame       = in_sr;
    assign sdo_pull    = ~cs_q & ~out_sr[FRAME_BITS-1];

endmodule

// File: rtl/busy_timer.sv
`timescale 1ns/1ps
module busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/wiper_bank.sv
`timescale 1ns/1ps
module wiper_bank
    import dpot_pkg::*;
#(
    parameter int CHANNELS = 2,
    parameter int CODE_W   = 10,
    parameter int CH_W     = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_en,
    input  op_t                        op,
    input  logic                       hit,
    input  logic [CH_W-1:0]            ch,
    input  logic [CODE_W-1:0]          data,
    output logic [CHANNELS*CODE_W-1:0] wipers
);
    localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W - 1);

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        logic [CODE_W-1:0] wip_q, nv_q;
        logic              sel;

        assign sel = hit && (ch == CH_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wip_q <= HALF;
                nv_q  <= HALF;
            end else if (op_en) begin
                case (op)
                    OP_SET_WIPER:   if (sel) wip_q <= data;
                    OP_SAVE:        if (sel) nv_q  <= wip_q;
                    OP_RESTORE:     if (sel) wip_q <= nv_q;
                    OP_RESTORE_ALL: wip_q <= nv_q;
                    OP_NV_LOAD:     if (sel) nv_q  <= data;
                    OP_NV_MID:      if (sel) nv_q  <= HALF;
                    default: ;
                endcase
            end
        end

        assign wipers[i*CODE_W +: CODE_W] = wip_q;
    end

endmodule

// File: rtl/dpot_serial_ctrl.sv
`timescale 1ns/1ps
module dpot_serial_ctrl
    import dpot_pkg::*;
#(
    parameter int CHANNELS      = 2,
    parameter int CODE_W        = 10,
    parameter int SYNC_STAGES   = 2,
    parameter int LONG_CYCLES   = 2_000_000,
    parameter int MID_CYCLES    = 100_000,
    parameter int SHORT_CYCLES  = 10_000,
    parameter int PRESET_CYCLES = 100_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo_pull,
    input  logic                       preset_n,
    output logic                       rdy,
    output logic [CHANNELS*CODE_W-1:0] wiper_codes
);
    localparam int CH_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
    localparam int TMR_W = $clog2(LONG_CYCLES + MID_CYCLES + SHORT_CYCLES + PRESET_CYCLES + 1);

    ctrl_state_t st, st_nx;

    logic               cs_fall, frame_valid, frame_ok;
    logic [FRAME_W-1:0] frame, readback_q;
    logic               blocked_q;

    logic [SYNC_STAGES-1:0] pre_sh;
    logic                   pre_d, preset_fall;

    logic [CMD_W-1:0]  f_cmd;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    op_t               f_op;
    dly_t              f_dly;
    logic              f_hit;
    logic [CH_W-1:0]   f_ch;
    logic              unused_hi_bits;

    op_t               pend_op;
    logic              pend_hit;
    logic [CH_W-1:0]   pend_ch;
    logic [CODE_W-1:0] pend_data;

    logic              tmr_load, t_done;
    logic [TMR_W-1:0]  tmr_val;

    logic              bank_en, bank_hit;
    op_t               bank_op;
    logic [CH_W-1:0]   bank_ch;
    logic [CODE_W-1:0] bank_data;

    spi_frame_rx #(
        .FRAME_BITS (FRAME_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .readback   (readback_q),
        .sdo_pull   (sdo_pull),
        .cs_fall    (cs_fall),
        .frame_valid(frame_valid),
        .frame      (frame)
    );

    busy_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (t_done)
    );

    wiper_bank #(
        .CHANNELS(CHANNELS),
        .CODE_W  (CODE_W),
        .CH_W    (CH_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .op_en (bank_en),
        .op    (bank_op),
        .hit   (bank_hit),
        .ch    (bank_ch),
        .data  (bank_data),
        .wipers(wiper_codes)
    );

    // preset synchronizer and falling-edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_sh <= '1;
            pre_d  <= 1'b1;
        end else begin
            pre_sh <= {pre_sh[SYNC_STAGES-2:0], preset_n};
            pre_d  <= pre_sh[SYNC_STAGES-1];
        end
    end
    assign preset_fall = pre_d & ~pre_sh[SYNC_STAGES-1];

    // frame field split
    assign f_cmd          = frame[FRAME_W-1 -: CMD_W];
    assign f_addr         = frame[DATA_W +: ADDR_W];
    assign f_data         = frame[DATA_W-1:0];
    assign f_op           = decode_op(f_cmd);
    assign f_dly          = decode_dly(f_cmd);
    assign f_hit          = (f_addr < ADDR_W'(CHANNELS));
    assign f_ch           = f_addr[CH_W-1:0];
    assign unused_hi_bits = ^f_data[DATA_W-1:CODE_W];

    assign frame_ok = frame_valid && !blocked_q && (st == ST_IDLE) && !preset_fall;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (preset_fall)                          st_nx = ST_WAIT;
                else if (frame_ok && (f_dly != DLY_NONE)) st_nx = ST_WAIT;
            end
            ST_WAIT:  if (t_done) st_nx = ST_APPLY;
            ST_APPLY: st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // frame bookkeeping: rejection flag, readback, deferred operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blocked_q  <= 1'b0;
            readback_q <= '0;
            pend_op    <= OP_NONE;
            pend_hit   <= 1'b0;
            pend_ch    <= '0;
            pend_data  <= '0;
        end else begin
            if (cs_fall) blocked_q <= (st != ST_IDLE);
            if (frame_ok) readback_q <= frame;
            if (st == ST_IDLE) begin
                if (preset_fall) begin
                    pend_op  <= OP_RESTORE_ALL;
                    pend_hit <= 1'b0;
                end else if (frame_ok) begin
                    pend_op   <= f_op;
                    pend_hit  <= f_hit;
                    pend_ch   <= f_ch;
                    pend_data <= f_data[CODE_W-1:0];
                end
            end
        end
    end

    // outputs of the controller
    always_comb begin
        rdy       = (st == ST_IDLE);
        tmr_load  = 1'b0;
        tmr_val   = TMR_W'(PRESET_CYCLES);
        bank_en   = 1'b0;
        bank_op   = pend_op;
        bank_hit  = pend_hit;
        bank_ch   = pend_ch;
        bank_data = pend_data;
        unique case (st)
            ST_IDLE: begin
                if (preset_fall) begin
                    tmr_load = 1'b1;
                end else if (frame_ok) begin
                    unique case (f_dly)
                        DLY_LONG:  tmr_val = TMR_W'(LONG_CYCLES);
                        DLY_MID:   tmr_val = TMR_W'(MID_CYCLES);
                        DLY_SHORT: tmr_val = TMR_W'(SHORT_CYCLES);
                        default:   tmr_val = TMR_W'(PRESET_CYCLES);
                    endcase
                    tmr_load = (f_dly != DLY_NONE);
                    if (f_op == OP_SET_WIPER) begin
                        bank_en   = 1'b1;
                        bank_op   = f_op;
                        bank_hit  = f_hit;
                        bank_ch   = f_ch;
                        bank_data = f_data[CODE_W-1:0];
                    end
                end
            end
            ST_WAIT:  ;
            ST_APPLY: bank_en = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dpot_ctrl_chk.sv
`timescale 1ns/1ps
module dpot_ctrl_chk
    import dpot_pkg::*;
#(
    parameter int CODES_W     = 20,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_LOW     = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               sdo_pull,
    input logic               rdy,
    input logic [CODES_W-1:0] wiper_codes,
    input ctrl_state_t        st,
    input logic               t_done
);
    int unsigned cs_hi_cnt;
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hi_cnt <= 0;
            low_cnt   <= 0;
        end else begin
            if (!cs_n)                cs_hi_cnt <= 0;
            else if (cs_hi_cnt < 1000) cs_hi_cnt <= cs_hi_cnt + 1;
            if (rdy)                   low_cnt <= 0;
            else                       low_cnt <= low_cnt + 1;
        end
    end

    // R5
    sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt > SYNC_STAGES) |-> !sdo_pull);

    // R13
    wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> $stable(wiper_codes));

    // R6
    busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= MAX_LOW);

    // R6
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |=> (st == ST_WAIT || st == ST_APPLY));

    // R13
    apply_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_APPLY) |=> (st == ST_IDLE && rdy));

    // R11
    done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |-> (st == ST_WAIT));

endmodule

bind dpot_serial_ctrl dpot_ctrl_chk #(
    .CODES_W    (CHANNELS * CODE_W),
    .SYNC_STAGES(SYNC_STAGES),
    .MAX_LOW    (LONG_CYCLES + PRESET_CYCLES + 4)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo_pull   (sdo_pull),
    .rdy        (rdy),
    .wiper_codes(wiper_codes),
    .st         (st),
    .t_done     (t_done)
);

// File: tb/tb_dpot_serial_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_serial_ctrl;
    localparam int LONG  = 40;
    localparam int MID   = 20;
    localparam int SHORT = 10;
    localparam int PRE   = 15;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, preset_n = 1'b1;
    wire        sdo_pull, rdy;
    wire [19:0] wiper_codes;

    always #2.5 clk = ~clk;

    dpot_serial_ctrl #(
        .LONG_CYCLES(LONG), .MID_CYCLES(MID), .SHORT_CYCLES(SHORT), .PRESET_CYCLES(PRE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo_pull(sdo_pull), .preset_n(preset_n), .rdy(rdy), .wiper_codes(wiper_codes)
    );

    int checks = 0, fails = 0;
    logic [9:0]  mw [2];
    logic [9:0]  mnv[2];
    logic [23:0] mrb;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int busy_len(input logic [3:0] c);
        case (c)
            4'd2, 4'd3:  return LONG;
            4'd8:        return MID;
            4'd9, 4'd10: return SHORT;
            default:     return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1:        return "R2";
            4'd2:        return "R6";
            4'd3:        return "R7";
            4'd8:        return "R8";
            4'd9, 4'd10: return "R9";
            default:     return "R12";
        endcase
    endfunction

    function automatic logic [19:0] exp_w();
        return {mw[1], mw[0]};
    endfunction

    task automatic model_apply(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        bit hit = (a < 4'd2);
        int ch  = a[0];
        case (c)
            4'd1:  if (hit) mw[ch]  = d[9:0];
            4'd2:  if (hit) mnv[ch] = mw[ch];
            4'd3:  if (hit) mw[ch]  = mnv[ch];
            4'd8:  begin mw[0] = mnv[0]; mw[1] = mnv[1]; end
            4'd9:  if (hit) mnv[ch] = d[9:0];
            4'd10: if (hit) mnv[ch] = 10'h200;
            default: ;
        endcase
    endtask

    task automatic measure_low(input int n, input string req);
        int waitc = 0;
        int cnt = 0;
        bit moved = 0;
        logic [19:0] w0;
        while (rdy && waitc < 12) begin @(negedge clk); waitc++; end
        w0 = wiper_codes;
        while (!rdy && cnt < n + 50) begin
            if (wiper_codes != w0) moved = 1;
            cnt++;
            @(negedge clk);
        end
        check(cnt == n + 1, req, cnt, n + 1);
        check(!moved, "R13", moved, 0);
    endtask

    task automatic stay_high(input string req);
        bit dropped = 0;
        repeat (12) begin @(negedge clk); if (!rdy) dropped = 1; end
        check(!dropped, req, dropped, 0);
    endtask

    task automatic wait_idle();
        while (!rdy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input logic [3:0] cmd, input logic [3:0] adr, input logic [15:0] dat,
                        input int nbits, input bit mode3, input bit wait_rdy);
        logic [23:0] f, got, mask;
        bit idle_start, acc;
        int n;
        string rq;
        f   = {cmd, adr, dat};
        got = '0;
        sclk = mode3;
        repeat (4) @(negedge clk);
        idle_start = rdy;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = (i < 24) ? f[23-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < 24) got[23-i] = ~sdo_pull;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = mode3;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        n    = (nbits < 24) ? nbits : 24;
        mask = ~24'h0 << (24 - n);
        check((got & mask) == (mrb & mask), "R5", got & mask, mrb & mask);
        acc = (nbits == 24) && idle_start;
        rq  = (nbits != 24) ? "R3" : (!idle_start ? "R10" : req_of(cmd));
        if (acc) begin
            mrb = f;
            model_apply(cmd, adr, dat);
        end
        n = acc ? busy_len(cmd) : 0;
        if (wait_rdy) begin
            if (n > 0) measure_low(n, rq);
            else       stay_high(rq);
            check(wiper_codes == exp_w(), rq, wiper_codes, exp_w());
        end
    endtask

    task automatic pulse_preset();
        preset_n = 1'b0;
        repeat (3) @(negedge clk);
        preset_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the run completed");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] cmds [9];
        cmds = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd5, 4'd15};
        mw[0] = 10'h200; mw[1] = 10'h200; mnv[0] = 10'h200; mnv[1] = 10'h200;
        mrb = '0;
        void'($urandom(32'h5eed_0042));

        repeat (5) @(negedge clk);
        // R1: reset state
        check(rdy == 1'b1, "R1", rdy, 1);
        check(wiper_codes == 20'h80200, "R1", wiper_codes, 20'h80200);
        check(sdo_pull == 1'b0, "R1", sdo_pull, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rdy == 1'b1 && sdo_pull == 1'b0, "R1", {rdy, sdo_pull}, 2'b10);

        // R2 / R5: immediate write, readback of zeros after reset
        xfer(4'd1, 4'd0, 16'h03FF, 24, 1'b0, 1'b1);
        // R4: clock idling high, alternating pattern
        xfer(4'd1, 4'd1, 16'hFD55, 24, 1'b1, 1'b1);
        check(wiper_codes[19:10] == 10'h155, "R4", wiper_codes[19:10], 10'h155);
        check(sdo_pull == 1'b0, "R5", sdo_pull, 0);
        // R6: store channel 0
        xfer(4'd2, 4'd0, 16'h0000, 24, 1'b0, 1'b1);
        // R7: overwrite then recall
        xfer(4'd1, 4'd0, 16'h0001, 24, 1'b1, 1'b1);
        xfer(4'd3, 4'd0, 16'h0000, 24, 1'b0, 1'b1);
        check(wiper_codes[9:0] == 10'h3FF, "R7", wiper_codes[9:0], 10'h3FF);
        // R9 / R8: write stored copy, recall all
        xfer(4'd9, 4'd1, 16'h00AA, 24, 1'b1, 1'b1);
        xfer(4'd8, 4'd0, 16'h0000, 24, 1'b0, 1'b1);
        check(wiper_codes == {10'h0AA, 10'h3FF}, "R8", wiper_codes, {10'h0AA, 10'h3FF});
        // R9: clear stored copy to half scale then recall
        xfer(4'd10, 4'd1, 16'h0000, 24, 1'b0, 1'b1);
        xfer(4'd3, 4'd1, 16'h0000, 24, 1'b1, 1'b1);
        check(wiper_codes[19:10] == 10'h200, "R9", wiper_codes[19:10], 10'h200);
        // R3: wrong frame lengths
        xfer(4'd1, 4'd0, 16'h0123, 23, 1'b0, 1'b1);
        xfer(4'd1, 4'd0, 16'h0123, 25, 1'b1, 1'b1);
        // R12: unused command, out-of-range address
        xfer(4'd5, 4'd0, 16'h0155, 24, 1'b0, 1'b1);
        xfer(4'd1, 4'd3, 16'h0155, 24, 1'b0, 1'b1);
        xfer(4'd9, 4'd2, 16'h0155, 24, 1'b1, 1'b1);
        // R10: frame during busy is ignored, readback kept
        xfer(4'd2, 4'd1, 16'h0000, 24, 1'b0, 1'b0);
        xfer(4'd1, 4'd0, 16'h0077, 24, 1'b0, 1'b0);
        wait_idle();
        check(wiper_codes == exp_w(), "R10", wiper_codes, exp_w());
        xfer(4'd0, 4'd0, 16'h0000, 24, 1'b1, 1'b1);
        // R11: preset reloads from stored copies
        xfer(4'd9, 4'd0, 16'h0111, 24, 1'b0, 1'b1);
        xfer(4'd9, 4'd1, 16'h0222, 24, 1'b0, 1'b1);
        pulse_preset();
        measure_low(PRE, "R11");
        mw[0] = mnv[0]; mw[1] = mnv[1];
        check(wiper_codes == exp_w(), "R11", wiper_codes, exp_w());
        // R11: preset while busy is dropped
        xfer(4'd1, 4'd0, 16'h0333, 24, 1'b0, 1'b1);
        xfer(4'd2, 4'd1, 16'h0000, 24, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        pulse_preset();
        wait_idle();
        stay_high("R11");
        check(wiper_codes == exp_w(), "R11", wiper_codes, exp_w());

        // seeded random frames
        for (int k = 0; k < 40; k++) begin
            int r;
            int nb;
            r  = $urandom % 10;
            nb = (r == 0) ? 23 : (r == 1) ? 25 : 24;
            xfer(cmds[$urandom % 9], 4'($urandom % 4), 16'($urandom),
                 nb, 1'($urandom % 2), 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule